// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block is a per-core ring of pending stores. It sits between the stage that executes stores and a write port of the data cache. The issue stage claims one entry per store in program order and receives the entry's tag. The store's address half and its data half are written into that entry later, by two independent requests that may come in either order. Retirement marks entries as final in order. Only retired, complete entries go to the cache. They are sent oldest first, one per accepted cycle. When merging is enabled, two neighbouring retired stores to the same cache word can go out as a single write.

A load presents its own ring position, which is the tag the next store would receive. Only entries older than that position are searched. The youngest older store that overlaps the load decides the outcome. If that store covers every byte the load needs and its data has arrived, the data is forwarded. A partial overlap, missing data or an older store whose address is still unknown stalls the load. With no overlap the load goes on to the cache. A mis-speculation flush drops every entry that is not yet retired. Fence and atomic requests are told when the ring has drained.

Top module: `store_buffer`

## Requirements
- R1: After reset the ring is empty: `alloc_ok` is 1, `alloc_tag` is 0, `cm_valid` is 0, and `fence_done`/`amo_go` follow their requests at once.
- R2: Allocation hands out tags in program order, incrementing modulo 2*DEPTH. When DEPTH entries are held, `alloc_ok` is 0 and a request allocates nothing until a commit frees an entry.
- R3: The address half (`sa_*`) and the data half (`sd_*`) of an entry are written independently in either order. An entry counts as complete, for forwarding and for commit, only when both halves are present.
- R4: Retired complete entries are offered on `cm_*` strictly oldest-first. One is removed per cycle with `cm_valid` and `cm_ready` both high. While `cm_ready` is low, the offered entry stays offered with the same address.
- R5: When the youngest overlapping older store covers every byte of the load mask and holds its data, `ld_result` is 1 (forward) and `ld_data` equals that store's data word.
- R6: `ld_result` is 2 (stall) when any older store has no address yet, or when the youngest overlapping older store covers only part of the load bytes or lacks its data.
- R7: `ld_result` is 0 (pass to cache) when no older store overlaps the load. Entries at or after the load's tag are ignored.
- R8: `flush` discards all non-retired entries, so `alloc_tag` returns to the first discarded tag and those stores are no longer seen by loads. Retired entries remain and still commit.
- R9: While `fence_req` is high and the ring is non-empty, every load gets result 2. `fence_done` is 1 exactly when `fence_req` is high and the ring is empty.
- R10: `amo_go` is 1 only when `amo_req` is high and the ring is empty.
- R11: With COALESCE=1, two retired complete entries at the head with equal word address commit together. In that case `cm_merge` is 1, `cm_mask` is the OR of both masks, bytes in the younger mask come from the younger store and the rest come from the older store, and both entries are freed. Entries with different addresses, or a non-retired second entry, are never merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Claim an entry for the next store |
| alloc_ok | output | 1 | Claim is accepted this cycle |
| alloc_tag | output | PTR_W | Tag of the entry the next claim receives |
| sa_valid | input | 1 | Address half write |
| sa_tag | input | PTR_W | Entry written by the address half |
| sa_addr | input | ADDR_W | Word address of the store |
| sa_mask | input | BYTES | Byte mask of the store |
| sd_valid | input | 1 | Data half write |
| sd_tag | input | PTR_W | Entry written by the data half |
| sd_data | input | 8*BYTES | Store data word |
| retire | input | 1 | Mark the oldest non-retired entry as retired |
| flush | input | 1 | Drop all non-retired entries |
| ld_valid | input | 1 | Load search request |
| ld_tag | input | PTR_W | Load's ring position; only entries before it are searched |
| ld_addr | input | ADDR_W | Load word address |
| ld_mask | input | BYTES | Load byte mask |
| ld_result | output | 2 | 0 pass, 1 forward, 2 stall |
| ld_data | output | 8*BYTES | Forwarded data word |
| fence_req | input | 1 | Fence waiting for drain |
| fence_done | output | 1 | Fence may complete |
| amo_req | input | 1 | Atomic waiting for drain |
| amo_go | output | 1 | Atomic may proceed |
| cm_valid | output | 1 | Commit write offered to the cache |
| cm_ready | input | 1 | Cache accepts the offered write |
| cm_addr | output | ADDR_W | Commit word address |
| cm_mask | output | BYTES | Commit byte mask |
| cm_data | output | 8*BYTES | Commit data word |
| cm_merge | output | 1 | The offered write combines two entries |

## Verification
The assertions assume the environment never retires an entry before both of its halves are written. They also assume it never writes a half into a flushed or unallocated entry, and never raises `retire` in the same cycle as `flush`. Under those conditions the retired count can only shrink by what commits. The bench keeps to these rules: it writes both halves before any retire, it issues each control pulse in a cycle of its own, and after a flush it only writes to freshly allocated tags. Loads are presented with the tag the issue stage would give them, or deliberately with an earlier tag to exclude younger stores.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int unsigned SB_DEPTH_DEF  = 8;
    localparam int unsigned SB_ADDR_W_DEF = 32;
    localparam int unsigned SB_BYTES_DEF  = 8;

    // Outcome of a load search, as driven on ld_result.
    typedef enum logic [1:0] {
        LD_PASS  = 2'd0,
        LD_FWD   = 2'd1,
        LD_STALL = 2'd2
    } ld_res_e;

    // Number of pointer bits for a ring of the given depth (index plus wrap bit).
    function automatic int unsigned ptr_bits(input int unsigned depth);
        return $clog2(depth) + 1;
    endfunction
endpackage

// File: rtl/sb_ring.sv
module sb_ring #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = sb_pkg::ptr_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_fire,
    input  logic             retire_req,
    input  logic             flush,
    input  logic [1:0]       pop_n,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic [PTR_W-1:0] count,
    output logic [PTR_W-1:0] nret
);
    logic [PTR_W-1:0] rptr;
    logic [PTR_W-1:0] pend;

    assign count = tail - head;
    assign nret  = rptr - head;
    assign pend  = tail - rptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            rptr <= '0;
            tail <= '0;
        end else begin
            head <= head + PTR_W'(pop_n);
            if (flush) begin
                // speculative part of the ring is dropped; retired part stays
                tail <= rptr;
            end else begin
                if (alloc_fire) tail <= tail + PTR_W'(1);
                if (retire_req && pend != '0) rptr <= rptr + PTR_W'(1);
            end
        end
    end
endmodule

// File: rtl/sb_slots.sv
module sb_slots #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned BYTES  = 8,
    localparam int unsigned IDX_W  = $clog2(DEPTH),
    localparam int unsigned DATA_W = 8 * BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_fire,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic              sa_valid,
    input  logic [IDX_W-1:0]  sa_idx,
    input  logic [ADDR_W-1:0] sa_addr,
    input  logic [BYTES-1:0]  sa_mask,
    input  logic              sd_valid,
    input  logic [IDX_W-1:0]  sd_idx,
    input  logic [DATA_W-1:0] sd_data,
    output logic              s_av   [DEPTH],
    output logic              s_dv   [DEPTH],
    output logic [ADDR_W-1:0] s_addr [DEPTH],
    output logic [BYTES-1:0]  s_mask [DEPTH],
    output logic [DATA_W-1:0] s_data [DEPTH]
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit_alloc, hit_a, hit_d;
        assign hit_alloc = alloc_fire && alloc_idx == IDX_W'(g);
        assign hit_a     = sa_valid && sa_idx == IDX_W'(g);
        assign hit_d     = sd_valid && sd_idx == IDX_W'(g);

        always_ff @(posedge clk) begin
            if (rst) begin
                s_av[g] <= 1'b0;
                s_dv[g] <= 1'b0;
            end else begin
                if (hit_alloc) begin
                    s_av[g] <= 1'b0;
                    s_dv[g] <= 1'b0;
                end
                // a half written in the allocating cycle wins over the clear
                if (hit_a) s_av[g] <= 1'b1;
                if (hit_d) s_dv[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (hit_a) begin
                s_addr[g] <= sa_addr;
                s_mask[g] <= sa_mask;
            end
            if (hit_d) s_data[g] <= sd_data;
        end
    end
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned BYTES  = 8,
    localparam int unsigned IDX_W  = $clog2(DEPTH),
    localparam int unsigned PTR_W  = IDX_W + 1,
    localparam int unsigned DATA_W = 8 * BYTES
) (
    input  logic [PTR_W-1:0]  head,
    input  logic [PTR_W-1:0]  count,
    input  logic              s_av   [DEPTH],
    input  logic              s_dv   [DEPTH],
    input  logic [ADDR_W-1:0] s_addr [DEPTH],
    input  logic [BYTES-1:0]  s_mask [DEPTH],
    input  logic [DATA_W-1:0] s_data [DEPTH],
    input  logic [PTR_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [BYTES-1:0]  ld_mask,
    output logic              f_fwd,
    output logic              f_stall,
    output logic [DATA_W-1:0] f_data
);
    logic [PTR_W-1:0] n_old;
    logic [IDX_W-1:0] idx;
    logic             unk, part, hit;

    assign n_old = ld_tag - head;

    // Walk from oldest to youngest; each overlapping store overrides the verdict.
    always_comb begin
        unk    = 1'b0;
        part   = 1'b0;
        hit    = 1'b0;
        f_data = '0;
        idx    = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head[IDX_W-1:0] + IDX_W'(k);
            if (PTR_W'(k) < n_old && PTR_W'(k) < count) begin
                if (!s_av[idx]) begin
                    unk = 1'b1;
                end else if (s_addr[idx] == ld_addr && (s_mask[idx] & ld_mask) != '0) begin
                    if (s_dv[idx] && (ld_mask & ~s_mask[idx]) == '0) begin
                        hit    = 1'b1;
                        part   = 1'b0;
                        f_data = s_data[idx];
                    end else begin
                        hit  = 1'b0;
                        part = 1'b1;
                    end
                end
            end
        end
    end

    assign f_stall = unk | part;
    assign f_fwd   = hit & ~f_stall;
endmodule

// File: rtl/store_buffer.sv
module store_buffer
    import sb_pkg::*;
#(
    parameter int unsigned DEPTH    = SB_DEPTH_DEF,
    parameter int unsigned ADDR_W   = SB_ADDR_W_DEF,
    parameter int unsigned BYTES    = SB_BYTES_DEF,
    parameter bit          COALESCE = 1'b1,
    localparam int unsigned IDX_W  = $clog2(DEPTH),
    localparam int unsigned PTR_W  = IDX_W + 1,
    localparam int unsigned DATA_W = 8 * BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_req,
    output logic              alloc_ok,
    output logic [PTR_W-1:0]  alloc_tag,
    input  logic              sa_valid,
    input  logic [PTR_W-1:0]  sa_tag,
    input  logic [ADDR_W-1:0] sa_addr,
    input  logic [BYTES-1:0]  sa_mask,
    input  logic              sd_valid,
    input  logic [PTR_W-1:0]  sd_tag,
    input  logic [DATA_W-1:0] sd_data,
    input  logic              retire,
    input  logic              flush,
    input  logic              ld_valid,
    input  logic [PTR_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [BYTES-1:0]  ld_mask,
    output logic [1:0]        ld_result,
    output logic [DATA_W-1:0] ld_data,
    input  logic              fence_req,
    output logic              fence_done,
    input  logic              amo_req,
    output logic              amo_go,
    output logic              cm_valid,
    input  logic              cm_ready,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [BYTES-1:0]  cm_mask,
    output logic [DATA_W-1:0] cm_data,
    output logic              cm_merge
);
    logic [PTR_W-1:0]  head, tail, count, nret;
    logic [1:0]        pop_n;
    logic              alloc_fire, empty, full;
    logic              s_av   [DEPTH];
    logic              s_dv   [DEPTH];
    logic [ADDR_W-1:0] s_addr [DEPTH];
    logic [BYTES-1:0]  s_mask [DEPTH];
    logic [DATA_W-1:0] s_data [DEPTH];
    logic              f_fwd, f_stall;
    logic [DATA_W-1:0] f_data;
    logic [IDX_W-1:0]  hidx, nidx;
    logic              head_ok, pair_ok;
    ld_res_e           res;

    assign full       = count == PTR_W'(DEPTH);
    assign empty      = count == '0;
    assign alloc_ok   = !full && !flush;
    assign alloc_fire = alloc_req && alloc_ok;
    assign alloc_tag  = tail;

    sb_ring #(.DEPTH(DEPTH)) u_ring (
        .clk        (clk),
        .rst        (rst),
        .alloc_fire (alloc_fire),
        .retire_req (retire),
        .flush      (flush),
        .pop_n      (pop_n),
        .head       (head),
        .tail       (tail),
        .count      (count),
        .nret       (nret)
    );

    sb_slots #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BYTES(BYTES)) u_slots (
        .clk        (clk),
        .rst        (rst),
        .alloc_fire (alloc_fire),
        .alloc_idx  (tail[IDX_W-1:0]),
        .sa_valid   (sa_valid),
        .sa_idx     (sa_tag[IDX_W-1:0]),
        .sa_addr    (sa_addr),
        .sa_mask    (sa_mask),
        .sd_valid   (sd_valid),
        .sd_idx     (sd_tag[IDX_W-1:0]),
        .sd_data    (sd_data),
        .s_av       (s_av),
        .s_dv       (s_dv),
        .s_addr     (s_addr),
        .s_mask     (s_mask),
        .s_data     (s_data)
    );

    sb_fwd #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BYTES(BYTES)) u_fwd (
        .head    (head),
        .count   (count),
        .s_av    (s_av),
        .s_dv    (s_dv),
        .s_addr  (s_addr),
        .s_mask  (s_mask),
        .s_data  (s_data),
        .ld_tag  (ld_tag),
        .ld_addr (ld_addr),
        .ld_mask (ld_mask),
        .f_fwd   (f_fwd),
        .f_stall (f_stall),
        .f_data  (f_data)
    );

    // ---------------- load outcome ----------------
    always_comb begin
        res = LD_PASS;
        if (ld_valid) begin
            if ((fence_req && !empty) || f_stall) res = LD_STALL;
            else if (f_fwd)                       res = LD_FWD;
        end
    end
    assign ld_result = res;
    assign ld_data   = (res == LD_FWD) ? f_data : '0;

    // ---------------- drain waits ----------------
    assign fence_done = fence_req && empty;
    assign amo_go     = amo_req && empty;

    // ---------------- commit ----------------
    assign hidx    = head[IDX_W-1:0];
    assign nidx    = hidx + IDX_W'(1);
    assign head_ok = nret != '0 && s_av[hidx] && s_dv[hidx];

    if (COALESCE) begin : g_merge
        assign pair_ok = nret >= PTR_W'(2) && s_av[nidx] && s_dv[nidx]
                         && s_addr[nidx] == s_addr[hidx];
    end else begin : g_nomerge
        assign pair_ok = 1'b0;
    end

    assign cm_valid = head_ok;
    assign cm_merge = head_ok && pair_ok;
    assign cm_addr  = s_addr[hidx];
    assign cm_mask  = cm_merge ? (s_mask[hidx] | s_mask[nidx]) : s_mask[hidx];

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign cm_data[8*b +: 8] = (cm_merge && s_mask[nidx][b]) ? s_data[nidx][8*b +: 8]
                                                                 : s_data[hidx][8*b +: 8];
    end

    assign pop_n = (cm_valid && cm_ready) ? (cm_merge ? 2'd2 : 2'd1) : 2'd0;
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 32,
    localparam int unsigned PTR_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              alloc_ok,
    input logic              cm_valid,
    input logic              cm_ready,
    input logic [ADDR_W-1:0] cm_addr,
    input logic              cm_merge,
    input logic              fence_req,
    input logic              fence_done,
    input logic              amo_go,
    input logic              ld_valid,
    input logic [1:0]        ld_result,
    input logic              flush,
    input logic [PTR_W-1:0]  count,
    input logic [PTR_W-1:0]  nret,
    input logic [1:0]        pop_n
);
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        count <= PTR_W'(DEPTH));

    p_full_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        count == PTR_W'(DEPTH) |-> !alloc_ok);

    p_commit_hold_r4: assert property (@(posedge clk) disable iff (rst)
        cm_valid && !cm_ready |=> cm_valid && $stable(cm_addr));

    p_flush_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> count == nret && nret == $past(nret) - PTR_W'($past(pop_n)));

    p_fence_empty_r9: assert property (@(posedge clk) disable iff (rst)
        fence_done |-> count == '0 && !cm_valid);

    p_fence_stall_r9: assert property (@(posedge clk) disable iff (rst)
        ld_valid && fence_req && !fence_done |-> ld_result == 2'd2);

    p_amo_empty_r10: assert property (@(posedge clk) disable iff (rst)
        amo_go |-> count == '0);

    p_merge_pair_r11: assert property (@(posedge clk) disable iff (rst)
        cm_merge |-> cm_valid && nret >= PTR_W'(2));
endmodule

bind store_buffer sb_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_sb_checker (
    .clk        (clk),
    .rst        (rst),
    .alloc_ok   (alloc_ok),
    .cm_valid   (cm_valid),
    .cm_ready   (cm_ready),
    .cm_addr    (cm_addr),
    .cm_merge   (cm_merge),
    .fence_req  (fence_req),
    .fence_done (fence_done),
    .amo_go     (amo_go),
    .ld_valid   (ld_valid),
    .ld_result  (ld_result),
    .flush      (flush),
    .count      (count),
    .nret       (nret),
    .pop_n      (pop_n)
);

// File: tb/store_buffer_bench.sv
module store_buffer_bench;
    localparam int DEPTH = 4;
    localparam int AW    = 8;
    localparam int NB    = 4;
    localparam int PW    = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          alloc_req = 0, sa_valid = 0, sd_valid = 0, retire = 0, flush = 0;
    logic          ld_valid = 0, fence_req = 0, amo_req = 0, cm_ready = 0;
    logic [PW-1:0] sa_tag = 0, sd_tag = 0, ld_tag = 0;
    logic [AW-1:0] sa_addr = 0, ld_addr = 0;
    logic [NB-1:0] sa_mask = 0, ld_mask = 0;
    logic [31:0]   sd_data = 0;
    logic          alloc_ok, fence_done, amo_go, cm_valid, cm_merge;
    logic [PW-1:0] alloc_tag;
    logic [1:0]    ld_result;
    logic [31:0]   ld_data, cm_data;
    logic [AW-1:0] cm_addr;
    logic [NB-1:0] cm_mask;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    store_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .BYTES(NB), .COALESCE(1'b1)) u_store_buffer (
        .clk(clk), .rst(rst),
        .alloc_req(alloc_req), .alloc_ok(alloc_ok), .alloc_tag(alloc_tag),
        .sa_valid(sa_valid), .sa_tag(sa_tag), .sa_addr(sa_addr), .sa_mask(sa_mask),
        .sd_valid(sd_valid), .sd_tag(sd_tag), .sd_data(sd_data),
        .retire(retire), .flush(flush),
        .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr), .ld_mask(ld_mask),
        .ld_result(ld_result), .ld_data(ld_data),
        .fence_req(fence_req), .fence_done(fence_done),
        .amo_req(amo_req), .amo_go(amo_go),
        .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_addr(cm_addr),
        .cm_mask(cm_mask), .cm_data(cm_data), .cm_merge(cm_merge)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic do_store(input [AW-1:0] a, input [NB-1:0] m, input [31:0] d,
                            input bit wa, input bit wd, output [PW-1:0] tag);
        tag = alloc_tag;
        alloc_req = 1; sa_valid = wa; sa_tag = tag; sa_addr = a; sa_mask = m;
        sd_valid = wd; sd_tag = tag; sd_data = d;
        step();
        alloc_req = 0; sa_valid = 0; sd_valid = 0;
    endtask

    task automatic wr_addr(input [PW-1:0] tag, input [AW-1:0] a, input [NB-1:0] m);
        sa_valid = 1; sa_tag = tag; sa_addr = a; sa_mask = m;
        step();
        sa_valid = 0;
    endtask

    task automatic wr_data(input [PW-1:0] tag, input [31:0] d);
        sd_valid = 1; sd_tag = tag; sd_data = d;
        step();
        sd_valid = 0;
    endtask

    task automatic pulse_retire();
        retire = 1; step(); retire = 0;
    endtask

    task automatic pulse_flush();
        flush = 1; step(); flush = 0;
    endtask

    task automatic ld_chk(input string req, input [PW-1:0] tag, input [AW-1:0] a,
                          input [NB-1:0] m, input [1:0] er, input [31:0] ed);
        ld_valid = 1; ld_tag = tag; ld_addr = a; ld_mask = m;
        #1;
        chk(req, {30'd0, ld_result}, {30'd0, er});
        if (er == 2'd1) chk({req, " data"}, ld_data, ed);
        ld_valid = 0;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [PW-1:0] t, t1, t2, t0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 alloc_ok", alloc_ok, 1);
        chk("R1 alloc_tag", alloc_tag, 0);
        chk("R1 cm_valid", cm_valid, 0);
        fence_req = 1; amo_req = 1; #1;
        chk("R1 fence_done", fence_done, 1);
        chk("R1 amo_go", amo_go, 1);
        fence_req = 0; amo_req = 0;
        step();

        // R5 R6 R7 sweep: every store mask against every load mask
        for (int sm = 1; sm < 16; sm++) begin
            do_store(8'd5, sm[3:0], 32'hA0B0C0D0, 1, 1, t);
            for (int lm = 1; lm < 16; lm++) begin
                logic [1:0] er;
                if ((lm & sm) == 0)       er = 2'd0;
                else if ((lm & ~sm) == 0) er = 2'd1;
                else                      er = 2'd2;
                ld_chk("R5/R6/R7 sweep", alloc_tag, 8'd5, lm[3:0], er, 32'hA0B0C0D0);
            end
            // R7: a load older than the store ignores it
            ld_chk("R7 younger ignored", t, 8'd5, 4'hF, 2'd0, 0);
            pulse_flush();
            chk("R8 tag rewinds", alloc_tag, t);
        end

        // R3 / R6: halves arrive separately
        do_store(8'd0, 4'h0, 32'h1234_5678, 0, 1, t);
        ld_chk("R6 unknown address", alloc_tag, 8'd5, 4'hF, 2'd2, 0);
        wr_addr(t, 8'd9, 4'hF);
        ld_chk("R7 no overlap", alloc_tag, 8'd5, 4'hF, 2'd0, 0);
        ld_chk("R3 data then address", alloc_tag, 8'd9, 4'hF, 2'd1, 32'h1234_5678);
        do_store(8'd5, 4'hF, 0, 1, 0, t1);
        ld_chk("R6 data missing", alloc_tag, 8'd5, 4'hF, 2'd2, 0);
        wr_data(t1, 32'hCAFE_F00D);
        ld_chk("R3 address then data", alloc_tag, 8'd5, 4'hF, 2'd1, 32'hCAFE_F00D);
        pulse_flush();

        // R5: youngest older store wins
        do_store(8'd3, 4'hF, 32'h111, 1, 1, t1);
        do_store(8'd3, 4'hF, 32'h222, 1, 1, t2);
        ld_chk("R5 youngest", alloc_tag, 8'd3, 4'hF, 2'd1, 32'h222);
        ld_chk("R5 only older", t2, 8'd3, 4'hF, 2'd1, 32'h111);
        do_store(8'd3, 4'h3, 32'h333, 1, 1, t);
        ld_chk("R6 youngest partial", alloc_tag, 8'd3, 4'hF, 2'd2, 0);
        pulse_flush();

        // R2 full ring, R4 in-order commit
        t0 = alloc_tag;
        for (int i = 0; i < DEPTH; i++) begin
            do_store(AW'(i + 1), 4'hF, 32'h100 + i + 1, 1, 1, t);
            chk("R2 tag order", t, PW'(t0 + i));
        end
        chk("R2 full", alloc_ok, 0);
        alloc_req = 1; step(); alloc_req = 0;
        chk("R2 no alloc when full", alloc_tag, PW'(t0 + DEPTH));
        chk("R4 not retired", cm_valid, 0);
        pulse_retire();
        chk("R4 head offered", cm_valid, 1);
        chk("R4 head addr", cm_addr, 1);
        step();
        chk("R4 held", cm_valid, 1);
        chk("R4 held addr", cm_addr, 1);
        for (int i = 0; i < DEPTH - 1; i++) pulse_retire();
        cm_ready = 1;
        for (int i = 1; i <= DEPTH; i++) begin
            chk("R4 commit valid", cm_valid, 1);
            chk("R4 commit addr", cm_addr, i);
            chk("R4 commit data", cm_data, 32'h100 + i);
            chk("R11 no merge distinct", cm_merge, 0);
            step();
            if (i == 1) chk("R2 space after commit", alloc_ok, 1);
        end
        cm_ready = 0;
        chk("R4 drained", cm_valid, 0);

        // R8 flush keeps retired entry
        do_store(8'd7, 4'hF, 32'h777, 1, 1, t1);
        pulse_retire();
        do_store(8'd8, 4'hF, 32'h888, 1, 1, t2);
        pulse_flush();
        chk("R8 tag rewinds to first dropped", alloc_tag, t2);
        ld_chk("R8 dropped store unseen", alloc_tag, 8'd8, 4'hF, 2'd0, 0);
        ld_chk("R8 retired store kept", alloc_tag, 8'd7, 4'hF, 2'd1, 32'h777);
        chk("R8 retired offered", cm_valid, 1);
        chk("R8 retired addr", cm_addr, 7);
        cm_ready = 1; step(); cm_ready = 0;
        chk("R8 dropped never commits", cm_valid, 0);

        // R9 fence, R10 atomic
        do_store(8'd6, 4'hF, 32'h666, 1, 1, t);
        pulse_retire();
        fence_req = 1; amo_req = 1; #1;
        chk("R9 fence waits", fence_done, 0);
        chk("R10 atomic waits", amo_go, 0);
        ld_chk("R9 load blocked", alloc_tag, 8'd20, 4'hF, 2'd2, 0);
        cm_ready = 1; step(); cm_ready = 0;
        chk("R9 fence done", fence_done, 1);
        chk("R10 atomic go", amo_go, 1);
        ld_chk("R9 load free", alloc_tag, 8'd20, 4'hF, 2'd0, 0);
        fence_req = 0; amo_req = 0;

        // R11 coalescing
        do_store(8'd10, 4'h3, 32'h1122_3344, 1, 1, t1);
        do_store(8'd10, 4'h6, 32'hAABB_CCDD, 1, 1, t2);
        pulse_retire();
        chk("R11 second not retired", cm_merge, 0);
        chk("R11 single mask", cm_mask, 4'h3);
        pulse_retire();
        chk("R11 merge", cm_merge, 1);
        chk("R11 mask", cm_mask, 4'h7);
        chk("R11 data", cm_data & 32'h00FF_FFFF, 32'h00BB_CC44);
        cm_ready = 1; step(); cm_ready = 0;
        chk("R11 both freed", fence_done, 0);
        fence_req = 1; #1;
        chk("R11 both freed empty", fence_done, 1);
        fence_req = 0;
        do_store(8'd10, 4'hF, 32'h1, 1, 1, t);
        do_store(8'd11, 4'hF, 32'h2, 1, 1, t);
        do_store(8'd10, 4'hF, 32'h3, 1, 1, t);
        pulse_retire(); pulse_retire(); pulse_retire();
        cm_ready = 1;
        for (int i = 0; i < 3; i++) begin
            chk("R11 separated no merge", cm_merge, 0);
            chk("R11 separated order", cm_addr, (i == 1) ? 11 : 10);
            step();
        end
        cm_ready = 0;
        chk("R11 drained", cm_valid, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule